// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port shared memory of 1K words and watches the enable and address of both ports, called left and right. When both ports are enabled on the same word, it grants the word to the port that got there first. It pulls an active-low busy flag low toward the other port and withholds that port's write strobe from the array. Reads and writes are not told apart when the winner is chosen. Only enable and address count.

The arbiter runs on one clock. Each port's enable and address are compared with their values at the previous edge. A port whose request did not change across that edge was there first. When neither port was settled, or both were, the left port wins. The busy flags are registered, so they follow the decision by one edge. The write gating is combinational, so a losing write is stopped in the same cycle in which the contention appears.

A mode input turns the block into a follower for wider memories built from several such arrays. In follower mode no arbitration takes place. The busy outputs stay high, and each port's external busy input only blocks that port's writes. It can be driven from another block's busy outputs, or tied to a fixed level.

Top module: `dp_contention_arbiter`

## Requirements
- R1: In leader mode (`follow_mode`=0), the busy outputs go low only when both enables are high and the two addresses are equal. In any other cycle, both busy outputs are high after the next clock edge.
- R2: On a new match, the port whose enable was already high with the same address at the previous edge wins. One edge after the match appears, the other port's busy output goes low.
- R3: `lft_busy_n` and `rgt_busy_n` are never low in the same cycle.
- R4: On a new match where neither port was settled (both arrived in the same cycle, or the first cycle after reset), or both were, the left port wins and `rgt_busy_n` goes low.
- R5: The write strobes `lft_wr` and `rgt_wr` have no effect on either busy output.
- R6: In leader mode, `x_wr_ok` = `x_en & x_wr & ~lose`. Here lose is true for a port that does not win the current match. It applies in the same cycle as the inputs. The external busy inputs have no effect in leader mode.
- R7: A winner keeps priority for as long as the match holds, even if the other port becomes settled. The loser's busy output returns high at the edge after the match ends.
- R8: In follower mode both busy outputs are high after the next edge, whatever the addresses are.
- R9: In follower mode, `x_wr_ok` = `x_en & x_wr & x_busy_in_n`. A low busy input blocks every write from that port. With both inputs high, writes pass unrestricted.
- R10: While `rst_n` is low, both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| follow_mode | input | 1 | 0 = arbitrate (leader), 1 = busy inputs as write blocks |
| lft_en | input | 1 | Left port enable, active high |
| lft_wr | input | 1 | Left port write strobe |
| lft_addr | input | ADDR_W | Left port word address |
| rgt_en | input | 1 | Right port enable, active high |
| rgt_wr | input | 1 | Right port write strobe |
| rgt_addr | input | ADDR_W | Right port word address |
| lft_busy_in_n | input | 1 | Left write block in follower mode, active low |
| rgt_busy_in_n | input | 1 | Right write block in follower mode, active low |
| lft_busy_n | output | 1 | Registered busy toward left port, active low |
| rgt_busy_n | output | 1 | Registered busy toward right port, active low |
| lft_wr_ok | output | 1 | Gated left write enable to the array |
| rgt_wr_ok | output | 1 | Gated right write enable to the array |

## Verification
The write gating outputs are due in the same cycle as the inputs. The bench drives at the falling edge and checks them 1 ns later, before the next rising edge. The busy outputs are due one rising edge after the inputs that caused them, so the bench checks them 1 ns after that edge against a reference model that advances at the same edge. Directed sequences cover left-first and right-first arrival, a same-cycle tie, a hold and its release, write-strobe independence, and the follower-mode cases. Constrained random traffic on a four-word address window then keeps matches frequent.

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              follow_mode,
  input  logic              lft_en,
  input  logic              lft_wr,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic              rgt_en,
  input  logic              rgt_wr,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic              lft_busy_in_n,
  input  logic              rgt_busy_in_n,
  output logic              lft_busy_n,
  output logic              rgt_busy_n,
  output logic              lft_wr_ok,
  output logic              rgt_wr_ok
);

  typedef enum logic [1:0] {OWN_NONE, OWN_LEFT, OWN_RIGHT} owner_t;

  logic              same_word;
  logic              lft_en_q, rgt_en_q;
  logic [ADDR_W-1:0] lft_addr_q, rgt_addr_q;
  logic              lft_settled, rgt_settled;
  logic              lft_lose, rgt_lose;
  logic              lft_block, rgt_block;
  owner_t            own_q, own_d;

  assign same_word   = lft_en & rgt_en & (lft_addr == rgt_addr);
  assign lft_settled = lft_en_q & (lft_addr_q == lft_addr);
  assign rgt_settled = rgt_en_q & (rgt_addr_q == rgt_addr);

  always_comb begin
    own_d = OWN_NONE;
    if (!follow_mode && same_word) begin
      if (own_q != OWN_NONE)             own_d = own_q;
      else if (rgt_settled && !lft_settled) own_d = OWN_RIGHT;
      else                               own_d = OWN_LEFT;
    end
  end

  assign lft_lose  = (own_d == OWN_RIGHT);
  assign rgt_lose  = (own_d == OWN_LEFT);
  assign lft_block = follow_mode ? ~lft_busy_in_n : lft_lose;
  assign rgt_block = follow_mode ? ~rgt_busy_in_n : rgt_lose;
  assign lft_wr_ok = lft_en & lft_wr & ~lft_block;
  assign rgt_wr_ok = rgt_en & rgt_wr & ~rgt_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q      <= OWN_NONE;
      lft_en_q   <= 1'b0;
      rgt_en_q   <= 1'b0;
      lft_addr_q <= '0;
      rgt_addr_q <= '0;
      lft_busy_n <= 1'b1;
      rgt_busy_n <= 1'b1;
    end else begin
      own_q      <= own_d;
      lft_en_q   <= lft_en;
      rgt_en_q   <= rgt_en;
      lft_addr_q <= lft_addr;
      rgt_addr_q <= rgt_addr;
      lft_busy_n <= ~lft_lose;
      rgt_busy_n <= ~rgt_lose;
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !same_word |=> (lft_busy_n && rgt_busy_n));

  assert_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lft_busy_n && !rgt_busy_n));

  assert_hold_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!follow_mode && same_word && !lft_busy_n) |=> !lft_busy_n);

  assert_hold_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!follow_mode && same_word && !rgt_busy_n) |=> !rgt_busy_n);

  assert_gate_loser_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!follow_mode && same_word && (!lft_busy_n || !rgt_busy_n)) |->
      !((!lft_busy_n && lft_wr_ok) || (!rgt_busy_n && rgt_wr_ok)));

  assert_follow_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    follow_mode |=> (lft_busy_n && rgt_busy_n));

  assert_follow_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    follow_mode |-> !((!lft_busy_in_n && lft_wr_ok) || (!rgt_busy_in_n && rgt_wr_ok)));

endmodule

// File: tb/dp_contention_arbiter_tb_top.sv
module dp_contention_arbiter_tb_top;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, fm, le, lw, re, rw, lbi, rbi;
  logic [AW-1:0] la, ra;
  logic          lft_busy_n, rgt_busy_n, lft_wr_ok, rgt_wr_ok;

  dp_contention_arbiter #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .follow_mode(fm),
    .lft_en(le), .lft_wr(lw), .lft_addr(la),
    .rgt_en(re), .rgt_wr(rw), .rgt_addr(ra),
    .lft_busy_in_n(lbi), .rgt_busy_in_n(rbi),
    .lft_busy_n(lft_busy_n), .rgt_busy_n(rgt_busy_n),
    .lft_wr_ok(lft_wr_ok), .rgt_wr_ok(rgt_wr_ok));

  int n_chk = 0, n_fail = 0;

  logic          m_le_q = 0, m_re_q = 0;
  logic [AW-1:0] m_la_q = '0, m_ra_q = '0;
  int            m_own = 0;   // 0 none, 1 left won, 2 right won

  task automatic check(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic int decide();
    logic hit, ls, rs;
    hit = le && re && (la == ra);
    ls  = m_le_q && (m_la_q == la);
    rs  = m_re_q && (m_ra_q == ra);
    if (fm || !hit) return 0;
    if (m_own != 0) return m_own;
    if (rs && !ls) return 2;
    return 1;
  endfunction

  task automatic step(input logic s_fm, input logic s_le, input logic s_lw, input logic [AW-1:0] s_la,
                      input logic s_re, input logic s_rw, input logic [AW-1:0] s_ra,
                      input logic s_lbi, input logic s_rbi, input string tag_w, input string tag_b);
    int d;
    logic el, er;
    @(negedge clk);
    fm = s_fm; le = s_le; lw = s_lw; la = s_la; re = s_re; rw = s_rw; ra = s_ra; lbi = s_lbi; rbi = s_rbi;
    #1;
    d  = decide();
    el = le && lw && (fm ? lbi : (d != 2));
    er = re && rw && (fm ? rbi : (d != 1));
    check(tag_w, "wr_ok", {lft_wr_ok, rgt_wr_ok}, {el, er});
    @(posedge clk);
    #1;
    m_own = d; m_le_q = le; m_re_q = re; m_la_q = la; m_ra_q = ra;
    check(tag_b, "busy", {lft_busy_n, rgt_busy_n}, {d != 2, d != 1});
    check("R3", "not both low", {1'b0, !lft_busy_n && !rgt_busy_n}, 2'b00);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; fm = 0; le = 0; lw = 0; la = '0; re = 0; rw = 0; ra = '0; lbi = 1; rbi = 1;
    repeat (3) @(posedge clk);
    #1 check("R10", "busy in reset", {lft_busy_n, rgt_busy_n}, 2'b11);
    @(negedge clk) rst_n = 1;

    // left settles first, right arrives on the same word
    step(0, 1,0,10'd5, 0,0,10'd0, 1,1, "R6", "R1");
    step(0, 1,1,10'd5, 1,1,10'd5, 1,1, "R6", "R2");
    check("R2", "right loses", {lft_busy_n, rgt_busy_n}, 2'b10);
    step(0, 1,1,10'd5, 1,1,10'd5, 0,0, "R6", "R7");
    step(0, 1,0,10'd6, 1,1,10'd5, 1,1, "R6", "R7");
    check("R7", "released", {lft_busy_n, rgt_busy_n}, 2'b11);
    // right first
    step(0, 0,0,10'd0, 1,0,10'd7, 1,1, "R6", "R1");
    step(0, 1,1,10'd7, 1,1,10'd7, 1,1, "R6", "R2");
    check("R2", "left loses", {lft_busy_n, rgt_busy_n}, 2'b01);
    step(0, 0,1,10'd7, 1,1,10'd7, 1,1, "R6", "R7");
    // tie with reads, then tie with writes
    step(0, 0,0,10'd0, 0,0,10'd0, 1,1, "R6", "R1");
    step(0, 1,0,10'd9, 1,0,10'd9, 1,1, "R6", "R4");
    check("R4", "tie to left", {lft_busy_n, rgt_busy_n}, 2'b10);
    step(0, 0,0,10'd0, 0,0,10'd0, 1,1, "R6", "R1");
    step(0, 1,1,10'd9, 1,1,10'd9, 1,1, "R6", "R5");
    check("R5", "writes same result", {lft_busy_n, rgt_busy_n}, 2'b10);
    step(0, 1,0,10'd9, 1,0,10'd9, 1,1, "R6", "R5");
    // different words, both enabled
    step(0, 1,1,10'd1, 1,1,10'd2, 1,1, "R6", "R1");
    // follower mode
    step(1, 1,1,10'd3, 1,1,10'd3, 1,1, "R9", "R8");
    step(1, 1,1,10'd3, 1,1,10'd3, 0,1, "R9", "R8");
    step(1, 1,1,10'd4, 1,1,10'd8, 1,0, "R9", "R8");
    step(1, 1,1,10'd4, 1,1,10'd8, 0,0, "R9", "R8");
    step(0, 0,0,10'd0, 0,0,10'd0, 1,1, "R6", "R1");

    for (int i = 0; i < 3000; i++) begin
      logic s_fm;
      s_fm = ($urandom % 8) == 0;
      step(s_fm, $urandom%4 != 0, $urandom%2 == 1, AW'($urandom%4),
           $urandom%4 != 0, $urandom%2 == 1, AW'($urandom%4),
           $urandom%3 != 0, $urandom%3 != 0,
           s_fm ? "R9" : "R6", s_fm ? "R8" : "R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule